// File: doc/BRIEF.md
# Control-Register Bus Handshake Master

This block runs accesses on a narrow configuration bus that sits in front of a PHY's register file. The bus has one shared input word towards the PHY, four separate strobes (address capture, data capture, read, write), an acknowledge from the PHY and a read-data word back from it. Every step of an access is a complete four-phase exchange: the master raises one strobe, the PHY raises acknowledge, the master drops the strobe, and the PHY drops acknowledge.

The block takes a command (read or write, address, write data) through a single-cycle request that is honoured only while the block is idle. It then steps through the phases an access needs. A write runs address capture, then data capture, then the write strobe. A read runs address capture, then the read strobe, and takes the PHY's read word while acknowledge is high. When the last phase completes, the block pulses a done flag. A read result and a sticky timeout flag are reported with that pulse. Every wait for acknowledge, whether for its rise or its fall, is bounded by a cycle counter, so a silent PHY can never hang the sequence.

Top module: `crbus_master`

## Requirements
- R1: After a command is accepted, the first strobe raised is address capture, and while it is high the shared input word carries the command address, zero-extended.
- R2: A strobe stays high until acknowledge is seen high or the timeout expires. A strobe that falls without acknowledge has been high for exactly TIMEOUT_CYCLES cycles. No strobe is raised while acknowledge is still high from the previous phase.
- R3: A write raises, in order, address capture, data capture (input word = write data) and write (input word still = write data). A read raises only address capture and then read. A read never raises data capture or write.
- R4: In the read phase, the PHY's read word is captured in the cycle acknowledge is seen high. It is presented on rdata when done pulses and held until a later read captures again.
- R5: After reset, all strobes, busy, done, timed_out and rdata are low. At most one strobe is high at any time, and all strobes are low while idle.
- R6: busy is high from the cycle after a command is accepted until done. done is a one-cycle pulse, and busy is low in that cycle.
- R7: If acknowledge does not rise within TIMEOUT_CYCLES cycles of a strobe rising, the strobe is dropped and the sequence moves on. timed_out is then high with done and stays high until the next command is accepted. When acknowledge is first seen in the very cycle the count would expire, the acknowledge takes priority and no timeout is recorded.
- R8: A command request while busy is ignored: the running access is unchanged and no extra access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken only when idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Register address |
| cmd_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | Sticky: some wait in the last access expired |
| rdata | output | DATA_W | Last captured read word |
| bus_din | output | BUS_W | Shared word towards the PHY (address or data) |
| bus_cap_addr | output | 1 | Address-capture strobe |
| bus_cap_data | output | 1 | Data-capture strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ack | input | 1 | Acknowledge from the PHY |
| bus_dout | input | DATA_W | Read word from the PHY |

## Verification
The delicate case is an acknowledge that arrives in the same cycle as the timeout count reaches its limit. In that case the block has to record the acknowledge and capture the read word, not flag a timeout. The bench's PHY model can hold off acknowledge for a fixed count. One read holds every acknowledge to land exactly on the expiry cycle, and it must finish with correct data and timed_out low. A second read holds off one cycle longer, and it must report timed_out high with rdata unchanged.

// File: rtl/crbus_pkg.sv
package crbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_HIGH  = 2'd2,
        ST_LOW   = 2'd3
    } crbus_state_e;

    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_DATA = 2'd1,
        PH_XFER = 2'd2
    } crbus_phase_e;

    typedef struct packed {
        logic cap_addr;
        logic cap_data;
        logic rd;
        logic wr;
    } crbus_strb_t;

endpackage

// File: rtl/crbus_ack_timer.sv
module crbus_ack_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expired = run && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (run && (cnt_q != LAST))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: the wait counter never passes its limit
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/crbus_seq.sv
module crbus_seq
    import crbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_dout,
    input  logic              tmr_expired,
    output logic              tmr_clr,
    output logic              tmr_run,
    output logic              busy,
    output logic              done,
    output logic              timed_out,
    output logic [DATA_W-1:0] rdata,
    output logic [BUS_W-1:0]  bus_din,
    output crbus_strb_t       strb
);
    typedef struct packed {
        crbus_state_e      st;
        crbus_phase_e      ph;
        logic              wr_cmd;
        logic [DATA_W-1:0] wdata;
        logic [BUS_W-1:0]  din;
        crbus_strb_t       strb;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              tmo;
    } seq_t;

    seq_t d, q;

    function automatic crbus_strb_t phase_strobe(crbus_phase_e ph, logic wr);
        crbus_strb_t s;
        s = '0;
        case (ph)
            PH_ADDR: s.cap_addr = 1'b1;
            PH_DATA: s.cap_data = 1'b1;
            default: begin
                if (wr) s.wr = 1'b1;
                else    s.rd = 1'b1;
            end
        endcase
        return s;
    endfunction

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        tmr_clr = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.st     = ST_SETUP;
                    d.ph     = PH_ADDR;
                    d.wr_cmd = cmd_write;
                    d.wdata  = cmd_wdata;
                    d.din    = BUS_W'(cmd_addr);
                    d.tmo    = 1'b0;
                end
            end
            ST_SETUP: begin
                d.st    = ST_HIGH;
                d.strb  = phase_strobe(q.ph, q.wr_cmd);
                tmr_clr = 1'b1;
            end
            ST_HIGH: begin
                if (bus_ack) begin
                    if (q.ph == PH_XFER && !q.wr_cmd)
                        d.rdata = bus_dout;
                    d.strb  = '0;
                    d.st    = ST_LOW;
                    tmr_clr = 1'b1;
                end else if (tmr_expired) begin
                    d.strb  = '0;
                    d.tmo   = 1'b1;
                    d.st    = ST_LOW;
                    tmr_clr = 1'b1;
                end
            end
            default: begin
                if (!bus_ack || tmr_expired) begin
                    if (bus_ack) d.tmo = 1'b1;
                    case (q.ph)
                        PH_ADDR: begin
                            d.st = ST_SETUP;
                            if (q.wr_cmd) begin
                                d.ph  = PH_DATA;
                                d.din = BUS_W'(q.wdata);
                            end else begin
                                d.ph  = PH_XFER;
                            end
                        end
                        PH_DATA: begin
                            d.st = ST_SETUP;
                            d.ph = PH_XFER;
                        end
                        default: begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tmr_run   = (q.st == ST_HIGH) || (q.st == ST_LOW);
    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign timed_out = q.tmo;
    assign rdata     = q.rdata;
    assign bus_din   = q.din;
    assign strb      = q.strb;

    // R5: never two strobes at once
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.strb));
    // R5: bus quiet while idle
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (q.strb == '0));
    // R3: a read never touches data capture or the write strobe
    p_read_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !q.wr_cmd) |-> (!q.strb.cap_data && !q.strb.wr));
    // R2: a raised strobe holds while neither acknowledge nor expiry is seen
    p_hold_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.strb != '0) && !bus_ack && !tmr_expired) |=> $stable(q.strb));
    // R6: done lasts one cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: a request during an access leaves the captured command alone
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> ($stable(q.wr_cmd) && $stable(q.wdata)));

endmodule

// File: rtl/crbus_master.sv
module crbus_master
    import crbus_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int DATA_W         = 16,
    parameter int TIMEOUT_CYCLES = 64,
    parameter int BUS_W          = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic              timed_out,
    output logic [DATA_W-1:0] rdata,
    output logic [BUS_W-1:0]  bus_din,
    output logic              bus_cap_addr,
    output logic              bus_cap_data,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_dout
);
    logic        tmr_clr, tmr_run, tmr_expired;
    crbus_strb_t strb;

    crbus_ack_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    crbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_write   (cmd_write),
        .cmd_addr    (cmd_addr),
        .cmd_wdata   (cmd_wdata),
        .bus_ack     (bus_ack),
        .bus_dout    (bus_dout),
        .tmr_expired (tmr_expired),
        .tmr_clr     (tmr_clr),
        .tmr_run     (tmr_run),
        .busy        (busy),
        .done        (done),
        .timed_out   (timed_out),
        .rdata       (rdata),
        .bus_din     (bus_din),
        .strb        (strb)
    );

    assign bus_cap_addr = strb.cap_addr;
    assign bus_cap_data = strb.cap_data;
    assign bus_rd       = strb.rd;
    assign bus_wr       = strb.wr;

endmodule

// File: tb/test_crbus_master.sv
`timescale 1ns/1ps
module test_crbus_master;
    localparam int LIMIT = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [15:0] cmd_addr = '0, cmd_wdata = '0;
    logic        busy, done, timed_out;
    logic [15:0] rdata, bus_din;
    logic        bus_cap_addr, bus_cap_data, bus_rd, bus_wr;
    logic        bus_ack = 1'b0;
    logic [15:0] bus_dout = '0;

    always #2 clk = ~clk;

    crbus_master #(.ADDR_W(16), .DATA_W(16), .TIMEOUT_CYCLES(LIMIT)) i_crbus_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .timed_out(timed_out), .rdata(rdata), .bus_din(bus_din),
        .bus_cap_addr(bus_cap_addr), .bus_cap_data(bus_cap_data),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ack(bus_ack), .bus_dout(bus_dout)
    );

    typedef struct {
        bit          wr;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [15:0] exp_rdata;
        bit          exp_tmo;
    } item_t;

    item_t       exp_q[$];
    int          log_code[$];
    logic [15:0] log_din[$];
    int          n_checks = 0, n_fail = 0, n_done = 0, n_issued = 0;
    bit          resp_on = 1'b1;
    int          fixed_delay = -1;
    logic [15:0] resp_data = '0;
    logic [15:0] last_rdata = '0;
    bit          finished = 1'b0;

    wire [3:0] strb_vec = {bus_cap_addr, bus_cap_data, bus_rd, bus_wr};

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int code_of(logic [3:0] s);
        case (s)
            4'b1000: return 1;
            4'b0100: return 2;
            4'b0010: return 3;
            4'b0001: return 4;
            default: return 9;
        endcase
    endfunction

    // PHY-side model: acknowledges each strobe after a delay, holds until the strobe falls
    initial begin
        forever begin
            @(negedge clk);
            if (strb_vec != 4'b0) begin
                logic [3:0] cur;
                int dly, k;
                bit dropped;
                cur = strb_vec;
                log_code.push_back(code_of(cur));
                log_din.push_back(bus_din);
                chk(!bus_ack, "R2", "strobe raised while ack high", 1, 0);
                dly = (fixed_delay >= 0) ? fixed_delay : $urandom_range(0, 4);
                if (!resp_on) dly = 1000000;
                k = 0;
                dropped = 1'b0;
                while (k < dly && !dropped) begin
                    @(negedge clk);
                    k++;
                    if (strb_vec != cur) dropped = 1'b1;
                end
                if (dropped) begin
                    chk(k == LIMIT, "R2", "strobe high cycles without ack", k, LIMIT);
                end else begin
                    bus_dout = resp_data;
                    bus_ack  = 1'b1;
                    while (strb_vec != 4'b0) @(negedge clk);
                    repeat ($urandom_range(0, 3)) @(negedge clk);
                    bus_ack  = 1'b0;
                end
            end
        end
    end

    // Monitor: pops the expected item at every done pulse
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                n_done++;
                chk(!busy, "R6", "busy during done", busy, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected extra completion", n_done, n_issued);
                end else begin
                    item_t it;
                    int    ec[$];
                    logic [15:0] ed[$];
                    it = exp_q.pop_front();
                    if (it.wr) begin
                        ec = '{1, 2, 4};
                        ed = '{it.addr, it.wdata, it.wdata};
                    end else begin
                        ec = '{1, 3};
                        ed = '{it.addr, it.addr};
                    end
                    chk(log_code.size() == ec.size(), "R3", "phase count", log_code.size(), ec.size());
                    if (log_code.size() == ec.size()) begin
                        foreach (ec[i]) begin
                            chk(log_code[i] == ec[i], (i == 0) ? "R1" : "R3", "phase strobe", log_code[i], ec[i]);
                            chk(log_din[i] == ed[i], (i == 0) ? "R1" : "R3", "input word", log_din[i], ed[i]);
                        end
                    end
                    chk(rdata == it.exp_rdata, "R4", "read data", rdata, it.exp_rdata);
                    chk(timed_out == it.exp_tmo, "R7", "timeout flag", timed_out, it.exp_tmo);
                end
                log_code.delete();
                log_din.delete();
            end
        end
    end

    task automatic issue(bit wr, logic [15:0] a, logic [15:0] wd, logic [15:0] rv, bit tmo);
        item_t it;
        @(negedge clk);
        while (exp_q.size() != 0 || busy) @(negedge clk);
        resp_data = rv;
        it.wr = wr; it.addr = a; it.wdata = wd; it.exp_tmo = tmo;
        if (!wr && !tmo) last_rdata = rv;
        it.exp_rdata = last_rdata;
        exp_q.push_back(it);
        n_issued++;
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy, "R6", "busy after accept", busy, 1);
    endtask

    task automatic drain();
        @(negedge clk);
        while (exp_q.size() != 0 || busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R6", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R5: reset state
        chk(strb_vec == 4'b0, "R5", "strobes in reset", strb_vec, 0);
        chk(!busy && !done, "R5", "busy/done in reset", {busy, done}, 0);
        chk(!timed_out && rdata == 16'h0, "R5", "flags/rdata in reset", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(strb_vec == 4'b0, "R5", "strobes idle after reset", strb_vec, 0);

        issue(1'b1, 16'h102D, 16'h0080, 16'h0000, 1'b0);
        issue(1'b0, 16'h1006, 16'h0000, 16'h0BC3, 1'b0);
        for (int i = 0; i < 10; i++) begin
            logic [15:0] a, w, r;
            a = 16'($urandom); w = 16'($urandom); r = 16'($urandom);
            issue(i[0], a, w, r, 1'b0);
        end
        drain();

        // R8: requests while busy are ignored
        issue(1'b0, 16'h0030, 16'h0000, 16'h00A5, 1'b0);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 16'hDEAD; cmd_wdata = 16'hBEEF;
        repeat (2) @(negedge clk);
        cmd_valid = 1'b0;
        drain();
        chk(n_done == n_issued, "R8", "completion count", n_done, n_issued);

        // R7: silent PHY, read then write, flag sticky until next accept
        resp_on = 1'b0;
        issue(1'b0, 16'h1010, 16'h0000, 16'h7777, 1'b1);
        drain();
        chk(timed_out, "R7", "flag held after done", timed_out, 1);
        issue(1'b1, 16'h1002, 16'h3F7F, 16'h0000, 1'b1);
        drain();
        resp_on = 1'b1;
        issue(1'b1, 16'h0011, 16'h2222, 16'h0000, 1'b0);
        drain();

        // R7: acknowledge landing on the expiry cycle wins
        fixed_delay = LIMIT - 1;
        issue(1'b0, 16'h0042, 16'h0000, 16'h5A5A, 1'b0);
        drain();
        // R7: one cycle later the wait expires
        fixed_delay = LIMIT;
        issue(1'b0, 16'h0043, 16'h0000, 16'h1111, 1'b1);
        drain();
        fixed_delay = -1;
        chk(n_done == n_issued, "R6", "all accesses completed", n_done, n_issued);
        finish_run();
    end
endmodule